// File: doc/BRIEF.md
# Pulse Accumulator with Gated Mode

This block keeps an 8-bit running count driven by one external input. In event mode the count advances by one on each chosen transition of that input. In gated mode the count advances once per strobe of a slow internal tick, but only while the input sits at its chosen active level. This gives either a pulse count or a measure of how long the input stays active. One polarity bit serves both modes: it picks the transition to count in event mode and the active level in gated mode.

The input pin is asynchronous. It passes through a flop synchronizer before any decision is made. Software can load the count at any time. An enable input freezes counting and flag updates without blocking the load. Two sticky flags report events: one for a count wrap from 0xFF to 0x00, and one for the input. The input flag is set by a counted transition in event mode and by the end of the active level in gated mode. Each flag has its own clear strobe.

Top module: `pulse_accum_top`

## Requirements
- R1: While rst_n is low at a clock edge, count_o, ovf_flag_o and edge_flag_o all become 0, and so does the synchronizer state.
- R2: With mode_i=0 (event), pol_i=0 and enable_i=1, each rising transition of pin_i adds exactly one to count_o. A pin_i value first sampled at clock edge k shows in count_o after edge k+2.
- R3: With mode_i=0, pol_i=1 and enable_i=1, each falling transition of pin_i adds one to count_o, and rising transitions add nothing.
- R4: With mode_i=1 (gated) and enable_i=1, count_o adds one for each cycle in which tick_i=1 and the synchronized input is at the active level (high for pol_i=0, low for pol_i=1). With tick_i=0 or the input inactive, count_o holds.
- R5: With enable_i=0, count_o does not change except by a load, and neither flag is set, whatever pin_i and tick_i do.
- R6: wr_en_i=1 loads wr_data_i into count_o at the next edge, in either mode and whether or not counting is enabled. A load in the same cycle as a count step wins, and the step is lost.
- R7: A count step from 0xFF to 0x00 sets ovf_flag_o. Loading any value, 0xFF included, does not set it.
- R8: edge_flag_o is set in event mode by every counted transition. In gated mode it is set when the synchronized input leaves the active level: a falling transition for pol_i=0, a rising one for pol_i=1.
- R9: Both flags stay set until their clear strobe (ovf_clr_i or edge_clr_i) is 1 at an edge. When a set and a clear fall in the same cycle, the flag ends up set.
- R10: In event mode tick_i has no effect on count_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Asynchronous external input |
| tick_i | input | 1 | One-cycle slow tick strobe for gated mode |
| enable_i | input | 1 | 1 lets counting and flag setting proceed |
| mode_i | input | 1 | 0 event counting, 1 gated duration |
| pol_i | input | 1 | 0 rising edge / active high, 1 falling edge / active low |
| wr_en_i | input | 1 | Load strobe for the count |
| wr_data_i | input | 8 | Value to load |
| ovf_clr_i | input | 1 | Clear strobe for the wrap flag |
| edge_clr_i | input | 1 | Clear strobe for the input flag |
| count_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| edge_flag_o | output | 1 | Sticky input-event flag |

## Verification
Two pairs of actions can land in the same cycle: a software load and a count step, and a wrap that sets the overflow flag and its clear strobe. The bench provokes both in gated mode. It holds the input active so that the step timing is known, then raises tick_i together with wr_en_i, and later raises tick_i at count 0xFF together with ovf_clr_i. A load must leave exactly the written value with no increment, and a set must beat the clear. A behavioural reference model checks every cycle, and directed checks at fixed points confirm these outcomes.

// File: rtl/pa_pkg.sv
// Package: shared types for the pulse accumulator.
// Assumes: one-bit mode select, encoding fixed at the top-level port.
package pa_pkg;
    typedef enum logic {
        PA_EVENT = 1'b0,   // count selected transitions
        PA_GATED = 1'b1    // count ticks while input is active
    } pa_mode_e;
endpackage

// File: rtl/pa_sync_edge.sv
// Module: pa_sync_edge
// Brings an asynchronous input into the clock domain through a flop chain,
// then exposes the settled level and one-cycle rise/fall pulses.
// Assumes: STAGES >= 2; input may change at any time.
module pa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchronizer chain: stage 0 samples the pin, later stages follow.
    generate
        for (genvar st = 0; st < STAGES; st++) begin : g_stage
            if (st == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[st] <= 1'b0;
                    else        chain_q[st] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[st] <= 1'b0;
                    else        chain_q[st] <= chain_q[st-1];
                end
            end
        end
    endgenerate

    // Delay of the settled level, used for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Level and transition outputs.
    always_comb begin
        level_o = chain_q[STAGES-1];
        rise_o  = chain_q[STAGES-1] & ~prev_q;
        fall_o  = ~chain_q[STAGES-1] & prev_q;
    end

    // R2: a rise pulse lasts one cycle only.
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    // R3: a fall pulse lasts one cycle only.
    p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/pa_step_ctrl.sv
// Module: pa_step_ctrl
// Decides per cycle whether the count steps and whether the input flag
// is marked, based on mode, polarity, enable and the conditioned input.
// Assumes: rise/fall are one-cycle pulses from the synchronized level.
module pa_step_ctrl
    import pa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pa_mode_e mode_i,
    input  logic     pol_i,
    input  logic     enable_i,
    input  logic     tick_i,
    input  logic     level_i,
    input  logic     rise_i,
    input  logic     fall_i,
    output logic     step_o,
    output logic     mark_o
);
    logic lead_edge;   // selected transition for event mode
    logic trail_edge;  // end of the active level for gated mode
    logic gate_open;   // input at active level

    // Polarity decode shared by both modes.
    always_comb begin
        lead_edge  = pol_i ? fall_i : rise_i;
        trail_edge = pol_i ? rise_i : fall_i;
        gate_open  = level_i ^ pol_i;
    end

    // Step and mark selection by mode.
    always_comb begin
        step_o = 1'b0;
        mark_o = 1'b0;
        if (enable_i) begin
            case (mode_i)
                PA_EVENT: begin
                    step_o = lead_edge;
                    mark_o = lead_edge;
                end
                PA_GATED: begin
                    step_o = tick_i & gate_open;
                    mark_o = trail_edge;
                end
                default: ;
            endcase
        end
    end

    // R5: disabled means no step and no mark.
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> (!step_o && !mark_o));
    // R4: gated mode never steps without a tick.
    p_gated_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PA_GATED && !tick_i) |-> !step_o);
    // R10: event mode steps only on an input transition.
    p_event_needs_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PA_EVENT && !rise_i && !fall_i) |-> !step_o);
endmodule

// File: rtl/pa_counter.sv
// Module: pa_counter
// Loadable WIDTH-bit up counter; reports a wrap pulse when a step
// carries it from all-ones to zero. A load overrides a step.
// Assumes: step and load are single-cycle qualified requests.
module pa_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_data_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

    // Count register: load first, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_o <= '0;
        else if (load_i) count_o <= load_data_i;
        else if (step_i) count_o <= count_o + CNT_ONE;
    end

    // Wrap detect for a step out of the top value.
    always_comb wrap_o = step_i & ~load_i & (count_o == CNT_MAX);

    // R6: a load takes the written value.
    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_data_i)));
    // R2: a step without load adds exactly one.
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> ((count_o - $past(count_o)) == CNT_ONE));
    // R5: no request leaves the count unchanged.
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/pa_sticky.sv
// Module: pa_sticky
// Sticky status bit: set has priority over clear.
// Assumes: set and clear are single-cycle strobes.
module pa_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R9: a set always lands, even against a clear.
    p_set_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R9: a lone clear drops the flag.
    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R9: with no strobe the flag holds.
    p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/pulse_accum_top.sv
// Module: pulse_accum_top
// Pulse accumulator: counts selected input transitions (event mode) or
// slow ticks while the input is active (gated mode), with sticky wrap and
// input-event flags and a software load.
// Assumes: tick_i is a one-cycle strobe; pin_i is asynchronous.
module pulse_accum_top
    import pa_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic             mode_i,
    input  logic             pol_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             ovf_clr_i,
    input  logic             edge_clr_i,
    output logic [WIDTH-1:0] count_o,
    output logic             ovf_flag_o,
    output logic             edge_flag_o
);
    logic     in_level, in_rise, in_fall;
    logic     step, mark, wrap;
    pa_mode_e mode_sel;

    // Mode port decode to the shared type.
    always_comb mode_sel = pa_mode_e'(mode_i);

    pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .level_o(in_level), .rise_o(in_rise), .fall_o(in_fall)
    );

    pa_step_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_sel), .pol_i(pol_i),
        .enable_i(enable_i), .tick_i(tick_i), .level_i(in_level),
        .rise_i(in_rise), .fall_i(in_fall), .step_o(step), .mark_o(mark)
    );

    pa_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(wr_en_i), .load_data_i(wr_data_i),
        .step_i(step), .count_o(count_o), .wrap_o(wrap)
    );

    pa_sticky u_ovf (
        .clk(clk), .rst_n(rst_n), .set_i(wrap), .clr_i(ovf_clr_i),
        .flag_o(ovf_flag_o)
    );

    pa_sticky u_edge (
        .clk(clk), .rst_n(rst_n), .set_i(mark), .clr_i(edge_clr_i),
        .flag_o(edge_flag_o)
    );

    // R7: a load never raises the wrap flag by itself.
    p_load_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !ovf_flag_o) |=> !ovf_flag_o);
    // R1: state is zero in the cycle after reset.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && !ovf_flag_o && !edge_flag_o));
endmodule

// File: tb/tb_pulse_accum_top.sv
`timescale 1ns/1ps
module tb_pulse_accum_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0, tick = 1'b0, en = 1'b0, mode = 1'b0, pol = 1'b0;
    logic       wr = 1'b0, oclr = 1'b0, eclr = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] count;
    logic       ovf, edg;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // reference model state
    bit m_s1, m_s2, m_s3, m_ovf, m_edg;
    int m_cnt;

    always #2 clk = ~clk;

    pulse_accum_top dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .tick_i(tick), .enable_i(en),
        .mode_i(mode), .pol_i(pol), .wr_en_i(wr), .wr_data_i(wdata),
        .ovf_clr_i(oclr), .edge_clr_i(eclr),
        .count_o(count), .ovf_flag_o(ovf), .edge_flag_o(edg)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin : model
        bit rise, fall, go, mark, wrapv;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_ovf = 0; m_edg = 0;
        end else begin
            rise = m_s2 && !m_s3;
            fall = !m_s2 && m_s3;
            if (!en) begin go = 0; mark = 0; end
            else if (!mode) begin go = pol ? fall : rise; mark = go; end
            else begin go = tick && (m_s2 != pol); mark = pol ? rise : fall; end
            wrapv = 0;
            if (wr) m_cnt = wdata;
            else if (go) begin wrapv = (m_cnt == 255); m_cnt = (m_cnt + 1) % 256; end
            if (wrapv) m_ovf = 1; else if (oclr) m_ovf = 0;
            if (mark) m_edg = 1; else if (eclr) m_edg = 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " count"}, count, m_cnt);
            check({cur_req, " ovf"}, ovf, m_ovf);
            check({cur_req, " edge"}, edg, m_edg);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_write(int v);
        wr = 1; wdata = 8'(v); step(1); wr = 0;
    endtask
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; step(1); tick = 0; step(1);
        end
    endtask
    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            pin = 1; step(3); pin = 0; step(3);
        end
    endtask
    task automatic clear_flags();
        oclr = 1; eclr = 1; step(1); oclr = 0; eclr = 0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(3);
        cur_req = "R1";
        check("R1 count", count, 0);
        check("R1 ovf", ovf, 0);
        check("R1 edge", edg, 0);
        rst_n = 1;
        step(2);

        cur_req = "R2";
        en = 1; mode = 0; pol = 0;
        pulses(5); step(4);
        check("R2 five rising edges", count, 5);
        check("R8 event flag", edg, 1);

        cur_req = "R10";
        clear_flags();
        pin = 1; step(4);
        ticks(10);
        check("R10 ticks ignored", count, 6);
        pin = 0; step(4);

        cur_req = "R3";
        do_write(0); pol = 1;
        pulses(4); step(4);
        check("R3 falling edges", count, 4);

        cur_req = "R4";
        do_write(0); clear_flags();
        mode = 1; pol = 0;
        pin = 1; step(4);
        ticks(10);
        check("R4 gated high", count, 10);
        check("R8 no flag while active", edg, 0);
        cur_req = "R8";
        pin = 0; step(4);
        check("R8 trailing edge flag", edg, 1);
        cur_req = "R4";
        ticks(6);
        check("R4 inactive holds", count, 10);
        pol = 1; step(1);
        ticks(3);
        check("R4 gated active low", count, 13);

        cur_req = "R5";
        do_write(0); en = 0; clear_flags();
        mode = 0; pol = 0; pulses(3);
        mode = 1; pin = 1; step(4); ticks(5); pin = 0; step(4);
        check("R5 disabled count", count, 0);
        check("R5 disabled ovf", ovf, 0);
        check("R5 disabled edge", edg, 0);
        cur_req = "R6";
        do_write(33); step(1);
        check("R6 load while disabled", count, 33);
        en = 1;

        pin = 1; step(4);
        tick = 1; wr = 1; wdata = 8'd77; step(1);
        tick = 0; wr = 0; step(2);
        check("R6 load beats step", count, 77);

        cur_req = "R7";
        clear_flags();
        do_write(254); ticks(2); step(1);
        check("R7 wrap count", count, 0);
        check("R7 wrap flag", ovf, 1);
        cur_req = "R9";
        step(10);
        check("R9 flag sticky", ovf, 1);
        cur_req = "R7";
        clear_flags();
        do_write(255); step(2);
        check("R7 load ff no flag", ovf, 0);
        check("R7 load ff value", count, 255);

        cur_req = "R9";
        tick = 1; oclr = 1; step(1); tick = 0; oclr = 0; step(2);
        check("R9 set beats clear", ovf, 1);
        check("R9 wrap count", count, 0);
        oclr = 1; step(1); oclr = 0; step(2);
        check("R9 clear drops", ovf, 0);

        step(5);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule